// File: doc/BRIEF.md
# Hamming-3 Self-Correcting State Machine

This block is a sixteen-state synchronous controller whose current state lives in a seven-bit register. Each logical state is stored as a codeword of a Hamming(7,4) code, with the logical index as the four data bits. The remaining 112 patterns of the register are each exactly one bit away from one legal codeword. A register hit by a single-bit upset therefore still names its state without ambiguity. The next-state path first maps whatever the register holds back to a logical index. It then resolves that state's prioritised transitions, re-encodes the winner and stores a clean codeword. The upset is gone after one edge.

Eight control inputs drive the transitions. For each state, three conditions are tested in a fixed order, and the first true one wins. If none is true, the machine stays where it is. The block exposes the decoded logical index, the raw register, and a one-cycle flag raised after an edge at which the register held a corrupted (companion) code. A fault-injection input XORs a mask into the value written at an edge, so upsets can be produced on demand. A parameter selects between two equivalent correction circuits: a syndrome decoder, or a parallel search over all legal codes and their neighbours.

Top module: `hfsm_h3`

## Requirements
- R1: An active-low asynchronous reset, and a synchronous reset sampled at the clock edge, both load the code of state 0 (all seven bits zero) and clear the correction flag. The synchronous reset overrides every other input.
- R2: Legal state index d[3:0] is stored as code bits c[2]=d[0], c[4]=d[1], c[5]=d[2], c[6]=d[3], c[0]=d[0]^d[1]^d[3], c[1]=d[0]^d[2]^d[3], c[3]=d[1]^d[2]^d[3].
- R3: The state index output always equals the logical state whose legal code is within one bit of the register. This holds for every legal code and for every single-bit corruption of it.
- R4: From state s, if control bit (s mod 8) is 1, the next state is (s+1) mod 16. This condition has the highest priority.
- R5: Otherwise, if control bit ((s+3) mod 8) is 1, the next state is (s+7) mod 16.
- R6: Otherwise, if control bit ((s+5) mod 8) is 1, the next state is 0.
- R7: If none of the three conditions holds, the state is unchanged.
- R8: Transitions are taken from the decoded state, and the register is always written with a legal code (before fault injection). A corrupted code never survives past the next edge.
- R9: The correction flag is 1 for exactly the cycle after an edge at which the register held a non-legal code. Otherwise it is 0.
- R10: The fault-injection mask is XORed into the value stored at an edge. A zero mask has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_rst | input | 1 | Synchronous reset to state 0 |
| ctl | input | 8 | Transition control inputs |
| seu_inject | input | 7 | Mask XORed into the stored code (upset emulation) |
| state_idx | output | 4 | Decoded logical state index |
| state_code | output | 7 | Raw contents of the state register |
| corrected | output | 1 | Pulses after a companion code was corrected |

## Verification
The bench loads every one of the sixteen legal codes and corrupts each of its seven bits in turn. It checks that the index still names the right state, that the following edge rewrites a clean code, and that the flag rises for one cycle and then falls. A decoder with a wrong syndrome-to-bit mapping would report the wrong index or store a foreign code. A flag taken from the wrong cycle would appear late or stretch to two cycles. A prioritised vector walk covers several conditions true at once and the wraps at the top of the state space. A design with the wrong priority or wrong modular arithmetic would take the wrong branch. Further checks cover a transition taken from a corrupted state, synchronous reset overriding a pending injection, and asynchronous reset mid-run. These expose designs that act on the raw register or let injection beat reset.

// File: rtl/hfsm_pkg.sv
package hfsm_pkg;
   localparam int DATA_W = 4;
   localparam int CODE_W = 7;

   // offsets used by the prioritised transition rules
   localparam int COND_B_OFS = 3;
   localparam int COND_C_OFS = 5;
   localparam int JUMP_DIST  = 7;

   typedef enum logic {
      DEC_SYNDROME = 1'b0,
      DEC_SEARCH   = 1'b1
   } dec_mode_e;

   function automatic logic [CODE_W-1:0] h3_encode(input logic [DATA_W-1:0] d);
      logic [CODE_W-1:0] c;
      c[2] = d[0];
      c[4] = d[1];
      c[5] = d[2];
      c[6] = d[3];
      c[0] = d[0] ^ d[1] ^ d[3];
      c[1] = d[0] ^ d[2] ^ d[3];
      c[3] = d[1] ^ d[2] ^ d[3];
      return c;
   endfunction

   function automatic logic [DATA_W-1:0] h3_extract(input logic [CODE_W-1:0] c);
      return {c[6], c[5], c[4], c[2]};
   endfunction
endpackage

// File: rtl/hfsm_correct.sv
module hfsm_correct
   import hfsm_pkg::*;
#(
   parameter int        NUM_STATES = 16,
   parameter dec_mode_e MODE       = DEC_SYNDROME
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] idx_o,
   output logic              flipped_o
);
   if (MODE == DEC_SYNDROME) begin : g_syndrome
      logic [2:0]        syn;
      logic [CODE_W-1:0] flip_mask;
      logic [CODE_W-1:0] fixed;

      always_comb begin
         syn[0] = code_i[0] ^ code_i[2] ^ code_i[4] ^ code_i[6];
         syn[1] = code_i[1] ^ code_i[2] ^ code_i[5] ^ code_i[6];
         syn[2] = code_i[3] ^ code_i[4] ^ code_i[5] ^ code_i[6];
         if (syn == 3'd0) flip_mask = '0;
         else             flip_mask = CODE_W'(1) << (syn - 3'd1);
         fixed     = code_i ^ flip_mask;
         idx_o     = h3_extract(fixed);
         flipped_o = (syn != 3'd0);
      end
   end else begin : g_search
      logic [NUM_STATES-1:0] near;
      logic [NUM_STATES-1:0] exact;

      for (genvar st = 0; st < NUM_STATES; st++) begin : g_cmp
         localparam logic [CODE_W-1:0] LEGAL = h3_encode(DATA_W'(st));
         assign near[st]  = ($countones(code_i ^ LEGAL) <= 1);
         assign exact[st] = (code_i == LEGAL);
      end

      always_comb begin
         idx_o = '0;
         for (int st = 0; st < NUM_STATES; st++) begin
            if (near[st]) idx_o = DATA_W'(st);
         end
         flipped_o = ~(|exact);
      end
   end
endmodule

// File: rtl/hfsm_next.sv
module hfsm_next
   import hfsm_pkg::*;
#(
   parameter int NUM_STATES = 16,
   parameter int CTRL_W     = 8
) (
   input  logic [DATA_W-1:0] cur_idx,
   input  logic [CTRL_W-1:0] ctl,
   output logic [DATA_W-1:0] nxt_idx
);
   logic [DATA_W-1:0] cand [NUM_STATES];

   for (genvar st = 0; st < NUM_STATES; st++) begin : g_state
      localparam int BIT_A  = st % CTRL_W;
      localparam int BIT_B  = (st + COND_B_OFS) % CTRL_W;
      localparam int BIT_C  = (st + COND_C_OFS) % CTRL_W;
      localparam int DEST_A = (st + 1) % NUM_STATES;
      localparam int DEST_B = (st + JUMP_DIST) % NUM_STATES;

      always_comb begin
         if (ctl[BIT_A])      cand[st] = DATA_W'(DEST_A);
         else if (ctl[BIT_B]) cand[st] = DATA_W'(DEST_B);
         else if (ctl[BIT_C]) cand[st] = '0;
         else                 cand[st] = DATA_W'(st);
      end
   end

   always_comb begin
      nxt_idx = '0;
      for (int st = 0; st < NUM_STATES; st++) begin
         if (cur_idx == DATA_W'(st)) nxt_idx = cand[st];
      end
   end
endmodule

// File: rtl/hfsm_h3.sv
module hfsm_h3
   import hfsm_pkg::*;
#(
   parameter int        NUM_STATES = 16,
   parameter int        CTRL_W     = 8,
   parameter dec_mode_e DEC_MODE   = DEC_SYNDROME
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_rst,
   input  logic [CTRL_W-1:0] ctl,
   input  logic [CODE_W-1:0] seu_inject,
   output logic [DATA_W-1:0] state_idx,
   output logic [CODE_W-1:0] state_code,
   output logic              corrected
);
   localparam int CODE_SPACE = 2 ** CODE_W;
   localparam int NEED_CODES = NUM_STATES * (CODE_W + 1);
   localparam logic [CODE_W-1:0] HOME_CODE = h3_encode('0);

   if (NEED_CODES > CODE_SPACE) begin : g_bad_states
      $error("hfsm_h3: too many states for single-error correction");
   end
   if (NUM_STATES < 2 || NUM_STATES > 2 ** DATA_W) begin : g_bad_range
      $error("hfsm_h3: NUM_STATES out of range");
   end
   if (CTRL_W < 1) begin : g_bad_ctl
      $error("hfsm_h3: CTRL_W must be positive");
   end

   logic [CODE_W-1:0] code_q;
   logic              corr_q;
   logic [DATA_W-1:0] cur_idx;
   logic              cur_flipped;
   logic [DATA_W-1:0] nxt_idx;

   hfsm_correct #(
      .NUM_STATES (NUM_STATES),
      .MODE       (DEC_MODE)
   ) u_correct (
      .code_i    (code_q),
      .idx_o     (cur_idx),
      .flipped_o (cur_flipped)
   );

   hfsm_next #(
      .NUM_STATES (NUM_STATES),
      .CTRL_W     (CTRL_W)
   ) u_next (
      .cur_idx (cur_idx),
      .ctl     (ctl),
      .nxt_idx (nxt_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= HOME_CODE;
         corr_q <= 1'b0;
      end else if (sync_rst) begin
         code_q <= HOME_CODE;
         corr_q <= 1'b0;
      end else begin
         code_q <= h3_encode(nxt_idx) ^ seu_inject;
         corr_q <= cur_flipped;
      end
   end

   assign state_idx  = cur_idx;
   assign state_code = code_q;
   assign corrected  = corr_q;
endmodule

// File: rtl/hfsm_h3_chk.sv
module hfsm_h3_chk
   import hfsm_pkg::*;
#(
   parameter int CTRL_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_rst,
   input logic [CTRL_W-1:0] ctl,
   input logic [CODE_W-1:0] seu_inject,
   input logic [DATA_W-1:0] state_idx,
   input logic [CODE_W-1:0] state_code,
   input logic              corrected
);
   a_r1_sync_home: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst |=> (state_code == '0 && !corrected));

   a_r3_within_one: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_code ^ h3_encode(state_idx)) <= 1);

   a_r8_clean_store: assert property (@(posedge clk) disable iff (!rst_n)
      (seu_inject == '0) |=> (state_code == h3_encode(state_idx)));

   a_r9_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_rst && state_code != h3_encode(state_idx)) |=> corrected);

   a_r9_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == h3_encode(state_idx)) |=> !corrected);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_rst && ctl == '0 && seu_inject == '0) |=> (state_idx == $past(state_idx)));
endmodule

bind hfsm_h3 hfsm_h3_chk #(.CTRL_W(CTRL_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_rst   (sync_rst),
   .ctl        (ctl),
   .seu_inject (seu_inject),
   .state_idx  (state_idx),
   .state_code (state_code),
   .corrected  (corrected)
);

// File: tb/test_hfsm_h3.sv
module test_hfsm_h3;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       sync_rst;
   logic [7:0] ctl;
   logic [6:0] seu_inject;
   logic [3:0] state_idx;
   logic [6:0] state_code;
   logic       corrected;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   hfsm_h3 i_hfsm_h3 (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_rst   (sync_rst),
      .ctl        (ctl),
      .seu_inject (seu_inject),
      .state_idx  (state_idx),
      .state_code (state_code),
      .corrected  (corrected)
   );

   // expected code from the bit layout of R2
   function automatic logic [6:0] ref_code(input logic [3:0] d);
      logic [6:0] c;
      c = {d[3], d[2], d[1], d[1] ^ d[2] ^ d[3], d[0],
           d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
      return c;
   endfunction

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // {ctl, expected index after the edge}, walked from state 0
   localparam logic [11:0] VEC [12] = '{
      {8'h01, 4'd1},  // s0: A
      {8'h10, 4'd8},  // s1: B
      {8'h28, 4'd15}, // s8: B beats C
      {8'h94, 4'd0},  // s15: A beats B,C, wraps
      {8'h08, 4'd7},  // s0: B
      {8'h00, 4'd7},  // s7: hold
      {8'h7B, 4'd0},  // s7: C only
      {8'h01, 4'd1},  // s0: A
      {8'h02, 4'd2},  // s1: A
      {8'hA0, 4'd9},  // s2: B beats C
      {8'hFD, 4'd0},  // s9: B, 9+7 wraps to 0
      {8'hFF, 4'd1}   // s0: all true, A wins
   };

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; sync_rst = 1'b0; ctl = '0; seu_inject = '0;
      repeat (3) @(negedge clk);
      check("R1 reset code", state_code, 0);
      check("R1 reset idx", state_idx, 0);
      check("R1 reset flag", corrected, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R5 R6 R7 prioritised transitions
      for (int i = 0; i < 12; i++) begin
         ctl = VEC[i][11:4];
         @(negedge clk);
         check("R4/R5/R6/R7 table idx", state_idx, VEC[i][3:0]);
         check("R2 table code", state_code, ref_code(VEC[i][3:0]));
         check("R9 table flag low", corrected, 0);
      end
      ctl = '0;

      // every legal code, every single-bit upset
      for (int s = 0; s < 16; s++) begin
         for (int b = 0; b < 7; b++) begin
            sync_rst = 1'b1;
            @(negedge clk);
            sync_rst = 1'b0;
            seu_inject = ref_code(4'(s));
            @(negedge clk);
            seu_inject = 7'(1 << b);
            check("R10 load legal idx", state_idx, s);
            @(negedge clk);
            seu_inject = '0;
            check("R3 upset idx", state_idx, s);
            check("R10 upset code", state_code, ref_code(4'(s)) ^ 7'(1 << b));
            check("R9 flag before fix", corrected, 0);
            @(negedge clk);
            check("R8 repaired code", state_code, ref_code(4'(s)));
            check("R9 flag pulse", corrected, 1);
            @(negedge clk);
            check("R9 flag falls", corrected, 0);
         end
      end

      // transition evaluated from a corrupted state
      sync_rst = 1'b1; @(negedge clk); sync_rst = 1'b0;
      seu_inject = 7'h40; @(negedge clk); seu_inject = '0;
      ctl = 8'h01; @(negedge clk); ctl = '0;
      check("R8 move from upset idx", state_idx, 1);
      check("R8 move from upset code", state_code, ref_code(4'd1));
      check("R9 move from upset flag", corrected, 1);

      // synchronous reset beats injection and a pending flag
      seu_inject = 7'h04; @(negedge clk);
      seu_inject = 7'h05; sync_rst = 1'b1; @(negedge clk);
      seu_inject = '0; sync_rst = 1'b0;
      check("R1 sync reset code", state_code, 0);
      check("R1 sync reset flag", corrected, 0);

      // asynchronous reset mid-run
      ctl = 8'h01; @(negedge clk); ctl = '0;
      check("R4 before async reset", state_idx, 1);
      #3 rst_n = 1'b0;
      #2 check("R1 async reset immediate", state_code, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 idle after reset", state_idx, 0);

      summary();
      $finish;
   end
endmodule